// File: doc/BRIEF.md
# Host-to-Trust-Core Message Mailbox Controller

This block moves request and response messages between a host side and a trust-core side through a shared word memory. The host writes a request one word at a time into an inbound window of the memory and then marks it complete. The trust core is told that a request is waiting, reads it straight from the memory, takes ownership, and writes its answer into an outbound window. When it marks the answer done, the host sees a response flag and drains the answer word by word through the block.

The block walks a seven-state handshake: idle, receiving, request ready, responding, response ready, aborting and error. The host can abort at any time. The trust core can report an error that ends the exchange. The trust core can also issue a panic, which clears everything, a pending abort included, and returns to idle. The block bounds-checks every host access against the window registers, and a range lock freezes those registers. It also passes an interrupt-message address and data pair from the host to the trust core. The memory sits outside the block behind one synchronous-write port whose read data comes back in the same cycle.

Top module: `mailbox_ctl`

## Requirements
- R1: After reset the mailbox is idle with every status flag low, all window registers read zero, both windows are invalid and the range lock is clear.
- R2: A host push accepted in idle or receiving writes `socPushData` to the memory at the inbound base for the first word and at consecutive addresses after that. The first push moves the mailbox out of idle, so `socBusy` rises on the next cycle.
- R3: `socGo` while receiving raises `rotReqAvail` on the next cycle.
- R4: `rotTake` while a request is ready moves to responding, and `rotRespDone` while responding raises `socRespAvail` on the next cycle.
- R5: While a response is ready, each `socPopEn` inside the outbound window returns the word at the outbound base and then at consecutive addresses, on `socPopData` with `socPopValid` in the same cycle. A pop past the outbound limit gives no `socPopValid`. `socAck` returns the mailbox to idle.
- R6: `socAbort` moves any state to aborting, where `rotAbort` stays high and host pushes and pops do not touch the memory until a panic.
- R7: `rotError` in any state other than aborting raises `socErr` on the next cycle. `socAck` then returns to idle.
- R8: `rotPanic` returns the mailbox to idle on the next cycle from any state, even when an abort arrives in the same cycle.
- R9: A push whose address would lie past the inbound limit, or a push while the inbound window is invalid, writes no memory and does not advance the write address.
- R10: While the range lock is set, writes to selects 0 (inbound base), 1 (inbound limit), 2 (outbound base), 3 (outbound limit) and 4 (valid flags: bit0 inbound, bit1 outbound) are ignored. Select 5 bit0 is the lock, and `cfgRdata` returns the register chosen by `cfgSel`.
- R11: Writing 0 to the lock has effect only while the mailbox is idle. Writing 1 sets it in any state.
- R12: A host write of the interrupt-message address or data shows on `rotIntrAddr` or `rotIntrData` on the next cycle, and the trust core has no way to change them.
- R13: Whenever the mailbox returns to idle, the inbound write address and the outbound read address start again at their window bases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| socPushEn | input | 1 | Host writes one request word |
| socPushData | input | DW | Request word |
| socGo | input | 1 | Host marks request complete |
| socPopEn | input | 1 | Host reads one response word |
| socPopData | output | DW | Response word (same cycle) |
| socPopValid | output | 1 | Pop accepted this cycle |
| socAck | input | 1 | Host closes a response or error |
| socAbort | input | 1 | Host abort |
| socIntrAddrWr | input | 1 | Write interrupt-message address |
| socIntrDataWr | input | 1 | Write interrupt-message data |
| socIntrWdata | input | DW | Interrupt-message write value |
| socBusy | output | 1 | Mailbox not idle |
| socRespAvail | output | 1 | Response ready to read |
| socErr | output | 1 | Exchange ended in error |
| rotReqAvail | output | 1 | Request ready for trust core |
| rotAbort | output | 1 | Abort pending |
| rotTake | input | 1 | Trust core takes the request |
| rotRespDone | input | 1 | Trust core finished the response |
| rotError | input | 1 | Trust core error |
| rotPanic | input | 1 | Trust core panic to idle |
| rotIntrAddr | output | DW | Interrupt-message address |
| rotIntrData | output | DW | Interrupt-message data |
| cfgWrEn | input | 1 | Window/lock register write |
| cfgSel | input | 3 | Register select (see R10) |
| cfgWdata | input | DW | Register write value |
| cfgRdata | output | DW | Selected register value |
| memEn | output | 1 | Memory access |
| memWe | output | 1 | Memory write |
| memAddr | output | AW | Memory word address |
| memWdata | output | DW | Memory write data |
| memRdata | input | DW | Memory read data, same cycle |

## Verification
Most control faults surface within one cycle. A wrong next state shows as a status flag that rises late or stays low on the cycle after the strobe that should have set it. A pointer that fails to reload or advance places request words at the wrong memory address, or brings the wrong response word out in the same cycle as the pop. A broken bounds or lock check shows as a memory word or a window register that changes when it must hold. The scoreboard catches that on the first disallowed access.

// File: rtl/mailbox_pkg.sv
package mailbox_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RECV, ST_RXRDY, ST_RESP, ST_RESPRDY, ST_ABORT, ST_ERR
  } mbxState_e;

  typedef struct packed {
    logic pushWr;
    logic popRd;
    logic ptrLoad;
    logic lockClrOk;
  } mbxStrobe_t;
endpackage

// File: rtl/mailbox_fsm.sv
module mailbox_fsm
  import mailbox_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       socPushEn,
  input  logic       socGo,
  input  logic       socPopEn,
  input  logic       socAck,
  input  logic       socAbort,
  input  logic       rotTake,
  input  logic       rotRespDone,
  input  logic       rotError,
  input  logic       rotPanic,
  input  logic       inOk,
  input  logic       outOk,
  output mbxState_e  state,
  output mbxStrobe_t strb
);
  mbxState_e stateNext;
  logic      quiet;

  // no exceptional event this cycle
  assign quiet = !rotPanic && !socAbort && !rotError && (state != ST_ABORT);

  always_comb begin
    strb.pushWr    = quiet && socPushEn && inOk &&
                     (state == ST_IDLE || state == ST_RECV);
    strb.popRd     = quiet && socPopEn && outOk && (state == ST_RESPRDY);
    strb.ptrLoad   = (state == ST_IDLE);
    strb.lockClrOk = (state == ST_IDLE);
  end

  always_comb begin
    stateNext = state;
    if (rotPanic)                 stateNext = ST_IDLE;
    else if (socAbort)            stateNext = ST_ABORT;
    else if (state == ST_ABORT)   stateNext = ST_ABORT;
    else if (rotError)            stateNext = ST_ERR;
    else begin
      unique case (state)
        ST_IDLE:    if (strb.pushWr)  stateNext = ST_RECV;
        ST_RECV:    if (socGo)        stateNext = ST_RXRDY;
        ST_RXRDY:   if (rotTake)      stateNext = ST_RESP;
        ST_RESP:    if (rotRespDone)  stateNext = ST_RESPRDY;
        ST_RESPRDY: if (socAck)       stateNext = ST_IDLE;
        ST_ERR:     if (socAck)       stateNext = ST_IDLE;
        default:                      stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/mailbox_dp.sv
module mailbox_dp
  import mailbox_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  mbxStrobe_t    strb,
  input  logic [DW-1:0] socPushData,
  input  logic          socIntrAddrWr,
  input  logic          socIntrDataWr,
  input  logic [DW-1:0] socIntrWdata,
  input  logic          cfgWrEn,
  input  logic [2:0]    cfgSel,
  input  logic [DW-1:0] cfgWdata,
  input  logic [DW-1:0] memRdata,
  output logic          inOk,
  output logic          outOk,
  output logic [DW-1:0] socPopData,
  output logic          socPopValid,
  output logic [DW-1:0] rotIntrAddr,
  output logic [DW-1:0] rotIntrData,
  output logic [DW-1:0] cfgRdata,
  output logic          memEn,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  output logic [AW-1:0] inBase,
  output logic [AW-1:0] inLimit,
  output logic          lockQ
);
  localparam int PW = AW + 1;

  logic [AW-1:0] outBase, outLimit;
  logic          inValid, outValid;
  logic [PW-1:0] wrPtr, rdPtr, wrAddr;

  assign wrAddr = strb.ptrLoad ? {1'b0, inBase} : wrPtr;
  assign inOk   = inValid  && (wrAddr <= {1'b0, inLimit});
  assign outOk  = outValid && (rdPtr  <= {1'b0, outLimit});

  assign memEn       = strb.pushWr | strb.popRd;
  assign memWe       = strb.pushWr;
  assign memAddr     = strb.pushWr ? wrAddr[AW-1:0] : rdPtr[AW-1:0];
  assign memWdata    = socPushData;
  assign socPopData  = memRdata;
  assign socPopValid = strb.popRd;

  always_comb begin
    cfgRdata = '0;
    unique case (cfgSel)
      3'd0: cfgRdata[AW-1:0] = inBase;
      3'd1: cfgRdata[AW-1:0] = inLimit;
      3'd2: cfgRdata[AW-1:0] = outBase;
      3'd3: cfgRdata[AW-1:0] = outLimit;
      3'd4: cfgRdata[1:0]    = {outValid, inValid};
      3'd5: cfgRdata[0]      = lockQ;
      default: cfgRdata      = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inBase   <= '0;
      inLimit  <= '0;
      outBase  <= '0;
      outLimit <= '0;
      inValid  <= 1'b0;
      outValid <= 1'b0;
      lockQ    <= 1'b0;
    end else if (cfgWrEn) begin
      if (cfgSel == 3'd5) begin
        if (cfgWdata[0])         lockQ <= 1'b1;
        else if (strb.lockClrOk) lockQ <= 1'b0;
      end else if (!lockQ) begin
        unique case (cfgSel)
          3'd0: inBase   <= cfgWdata[AW-1:0];
          3'd1: inLimit  <= cfgWdata[AW-1:0];
          3'd2: outBase  <= cfgWdata[AW-1:0];
          3'd3: outLimit <= cfgWdata[AW-1:0];
          3'd4: {outValid, inValid} <= cfgWdata[1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strb.pushWr)       wrPtr <= wrAddr + 1'b1;
      else if (strb.ptrLoad) wrPtr <= {1'b0, inBase};
      if (strb.ptrLoad)      rdPtr <= {1'b0, outBase};
      else if (strb.popRd)   rdPtr <= rdPtr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rotIntrAddr <= '0;
      rotIntrData <= '0;
    end else begin
      if (socIntrAddrWr) rotIntrAddr <= socIntrWdata;
      if (socIntrDataWr) rotIntrData <= socIntrWdata;
    end
  end
endmodule

// File: rtl/mailbox_ctl.sv
module mailbox_ctl
  import mailbox_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          socPushEn,
  input  logic [DW-1:0] socPushData,
  input  logic          socGo,
  input  logic          socPopEn,
  output logic [DW-1:0] socPopData,
  output logic          socPopValid,
  input  logic          socAck,
  input  logic          socAbort,
  input  logic          socIntrAddrWr,
  input  logic          socIntrDataWr,
  input  logic [DW-1:0] socIntrWdata,
  output logic          socBusy,
  output logic          socRespAvail,
  output logic          socErr,
  output logic          rotReqAvail,
  output logic          rotAbort,
  input  logic          rotTake,
  input  logic          rotRespDone,
  input  logic          rotError,
  input  logic          rotPanic,
  output logic [DW-1:0] rotIntrAddr,
  output logic [DW-1:0] rotIntrData,
  input  logic          cfgWrEn,
  input  logic [2:0]    cfgSel,
  input  logic [DW-1:0] cfgWdata,
  output logic [DW-1:0] cfgRdata,
  output logic          memEn,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  input  logic [DW-1:0] memRdata
);
  mbxState_e     state;
  mbxStrobe_t    strb;
  logic          inOk, outOk, lockQ;
  logic [AW-1:0] inBase, inLimit;

  mailbox_fsm uFsm (
    .clk, .rstN, .socPushEn, .socGo, .socPopEn, .socAck, .socAbort,
    .rotTake, .rotRespDone, .rotError, .rotPanic, .inOk, .outOk,
    .state, .strb
  );

  mailbox_dp #(.AW(AW), .DW(DW)) uDp (
    .clk, .rstN, .strb, .socPushData, .socIntrAddrWr, .socIntrDataWr,
    .socIntrWdata, .cfgWrEn, .cfgSel, .cfgWdata, .memRdata, .inOk, .outOk,
    .socPopData, .socPopValid, .rotIntrAddr, .rotIntrData, .cfgRdata,
    .memEn, .memWe, .memAddr, .memWdata, .inBase, .inLimit, .lockQ
  );

  assign socBusy      = (state != ST_IDLE);
  assign socRespAvail = (state == ST_RESPRDY);
  assign socErr       = (state == ST_ERR);
  assign rotReqAvail  = (state == ST_RXRDY);
  assign rotAbort     = (state == ST_ABORT);
endmodule

// File: rtl/mailbox_ctl_chk.sv
module mailbox_ctl_chk
  import mailbox_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rstN,
  input mbxState_e     state,
  input logic          socAbort,
  input logic          rotError,
  input logic          rotPanic,
  input logic          socIntrAddrWr,
  input logic [DW-1:0] socIntrWdata,
  input logic [DW-1:0] rotIntrAddr,
  input logic          memWe,
  input logic [AW-1:0] memAddr,
  input logic [AW-1:0] inBase,
  input logic [AW-1:0] inLimit,
  input logic          lockQ
);
  // R8
  panic_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    rotPanic |=> state == ST_IDLE);

  // R6
  abort_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ABORT && !rotPanic) |=> state == ST_ABORT);

  // R6
  abort_nomem_chk: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_ABORT |-> !memWe);

  // R7
  err_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rotError && !rotPanic && !socAbort && state != ST_ABORT) |=> state == ST_ERR);

  // R9
  in_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memAddr <= inLimit);

  // R10
  lock_base_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockQ |=> $stable(inBase) && $stable(inLimit));

  // R11
  lock_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lockQ && state != ST_IDLE) |=> lockQ);

  // R12
  intr_relay_chk: assert property (@(posedge clk) disable iff (!rstN)
    socIntrAddrWr |=> rotIntrAddr == $past(socIntrWdata));
endmodule

bind mailbox_ctl mailbox_ctl_chk #(.AW(AW), .DW(DW)) uChk (
  .clk, .rstN, .state, .socAbort, .rotError, .rotPanic, .socIntrAddrWr,
  .socIntrWdata, .rotIntrAddr, .memWe, .memAddr, .inBase, .inLimit, .lockQ
);

// File: tb/mailbox_ctl_test.sv
`timescale 1ns/1ps
module mailbox_ctl_test;
  localparam int AW = 8;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic socPushEn = 0, socGo = 0, socPopEn = 0, socAck = 0, socAbort = 0;
  logic socIntrAddrWr = 0, socIntrDataWr = 0;
  logic [DW-1:0] socPushData = '0, socIntrWdata = '0, cfgWdata = '0;
  logic rotTake = 0, rotRespDone = 0, rotError = 0, rotPanic = 0;
  logic cfgWrEn = 0;
  logic [2:0] cfgSel = '0;
  logic [DW-1:0] socPopData, rotIntrAddr, rotIntrData, cfgRdata, memWdata, memRdata;
  logic socPopValid, socBusy, socRespAvail, socErr, rotReqAvail, rotAbort;
  logic memEn, memWe;
  logic [AW-1:0] memAddr;

  logic [DW-1:0] mem [2**AW];
  logic tbWe = 0;
  logic [AW-1:0] tbAddr = '0;
  logic [DW-1:0] tbData = '0;
  logic [DW-1:0] expQ [$];
  int nChk = 0, nFail = 0;

  always #5 clk = ~clk;

  mailbox_ctl #(.AW(AW), .DW(DW)) uut (.*);

  assign memRdata = mem[memAddr];

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 2**AW; i++) mem[i] <= 32'hDEAD_0000 + i;
    end else begin
      if (memEn && memWe) mem[memAddr] <= memWdata;
      if (tbWe) mem[tbAddr] <= tbData;
    end
  end

  task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    nChk++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // monitor: scoreboard pops compared with expected response words
  always @(negedge clk) begin
    if (rstN && socPopValid) begin
      if (expQ.size() == 0) chk("R5 unexpected pop", socPopData, 32'hxxxx_xxxx);
      else chk("R5 pop data", socPopData, expQ.pop_front());
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic cfgWr(input logic [2:0] sel, input logic [DW-1:0] d);
    cfgWrEn = 1; cfgSel = sel; cfgWdata = d; step(); cfgWrEn = 0;
  endtask

  task automatic cfgRd(input string req, input logic [2:0] sel, input logic [DW-1:0] exp);
    cfgSel = sel; #1; chk(req, cfgRdata, exp);
  endtask

  task automatic push(input logic [DW-1:0] d);
    socPushEn = 1; socPushData = d; step(); socPushEn = 0;
  endtask

  task automatic pulse(ref logic s);
    s = 1; step(); s = 0;
  endtask

  task automatic rotWrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    tbWe = 1; tbAddr = a; tbData = d; step(); tbWe = 0;
    expQ.push_back(d);
  endtask

  initial begin
    #2_000_000;
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (3) step();
    rstN = 1; step();
    // R1 reset state
    chk("R1 busy", socBusy, 0);
    chk("R1 flags", {socRespAvail, socErr, rotReqAvail, rotAbort}, 0);
    cfgRd("R1 lock", 3'd5, 0);
    cfgRd("R1 inBase", 3'd0, 0);
    cfgRd("R1 valid", 3'd4, 0);

    // R9 push while window invalid
    push(32'h1111_0000);
    chk("R9 invalid window no write", mem[0], 32'hDEAD_0000);
    chk("R9 invalid stays idle", socBusy, 0);

    cfgWr(0, 8); cfgWr(1, 11); cfgWr(2, 32); cfgWr(3, 34); cfgWr(4, 3);
    cfgRd("R10 inLimit readback", 3'd1, 11);

    // R2 request words
    push(32'hA000_0000);
    chk("R2 busy after first push", socBusy, 1);
    for (int k = 1; k < 4; k++) push(32'hA000_0000 + k);
    for (int k = 0; k < 4; k++) chk("R2 request word", mem[8+k], 32'hA000_0000 + k);
    push(32'hBAD0_0000);
    chk("R9 past limit no write", mem[12], 32'hDEAD_000C);

    pulse(socGo);
    chk("R3 request available", rotReqAvail, 1);
    pulse(rotTake);
    chk("R4 taken", rotReqAvail, 0);
    for (int k = 0; k < 3; k++) rotWrite(AW'(32 + k), 32'hC000_0000 + k);
    chk("R4 not ready before done", socRespAvail, 0);
    pulse(rotRespDone);
    chk("R4 response available", socRespAvail, 1);
    for (int k = 0; k < 4; k++) pulse(socPopEn);  // fourth is past the limit
    chk("R5 all words popped", expQ.size(), 0);
    pulse(socAck);
    chk("R5 idle after ack", socBusy, 0);

    // R10 lock
    cfgWr(5, 1);
    cfgWr(0, 50);
    cfgRd("R10 base frozen", 3'd0, 8);
    cfgWr(4, 0);
    cfgRd("R10 valid frozen", 3'd4, 3);

    // R11 lock clear refused while busy
    push(32'hE000_0000);
    cfgWr(5, 0);
    cfgRd("R11 lock kept busy", 3'd5, 1);
    chk("R13 pointer back at base", mem[8], 32'hE000_0000);

    // R6 abort
    pulse(socAbort);
    chk("R6 abort flag", rotAbort, 1);
    push(32'hE000_0001);
    chk("R6 push ignored", mem[9], 32'hA000_0001);
    step();
    chk("R6 abort held", rotAbort, 1);

    // R8 panic, together with abort
    socAbort = 1; rotPanic = 1; step(); socAbort = 0; rotPanic = 0;
    chk("R8 panic over abort", {socBusy, rotAbort}, 0);
    cfgWr(5, 0);
    cfgRd("R11 lock cleared idle", 3'd5, 0);

    // R13 second request restarts at base
    push(32'hF000_0000); push(32'hF000_0001);
    chk("R13 restart word0", mem[8], 32'hF000_0000);
    chk("R13 restart word1", mem[9], 32'hF000_0001);

    // R7 error
    pulse(rotError);
    chk("R7 error flag", socErr, 1);
    pulse(socAck);
    chk("R7 idle after ack", {socBusy, socErr}, 0);

    // R8 panic from a mid-exchange state
    push(32'h1234_0000); pulse(socGo);
    pulse(rotPanic);
    chk("R8 panic from ready", {socBusy, rotReqAvail}, 0);

    // R12 interrupt message relay
    socIntrWdata = 32'h0ADD_0001; pulse(socIntrAddrWr);
    chk("R12 intr addr", rotIntrAddr, 32'h0ADD_0001);
    socIntrWdata = 32'h0DA7_0002; pulse(socIntrDataWr);
    chk("R12 intr data", rotIntrData, 32'h0DA7_0002);
    chk("R12 addr untouched", rotIntrAddr, 32'h0ADD_0001);

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule